// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether an incoming Ethernet frame should be kept. The decision uses the frame's destination address and its length. The block holds four pieces of state:

- the station's own unicast address;
- a minimum frame length;
- three policy flags: accept everything, refuse broadcasts, and allow group (multicast) addresses;
- a 64-bit group hash table.

Software fills the hash table by streaming a list of 6-byte group addresses into the block. A byte count is given when the load starts. Each address is run through the Ethernet CRC-32, one byte per clock, and six bits of the result pick the table bit to set.

To test a frame, the receive path presents the destination address and the length with a one-cycle request strobe. The block runs the same serial CRC over the six destination bytes. It then classifies the address, always in the same priority order: promiscuous first, then broadcast, then group hash, then exact unicast match. One cycle after the CRC completes, it returns a registered accept/reject verdict with a one-cycle valid pulse. A separate flag marks accepted broadcast and group frames.

Frames are refused outright while the receiver is disabled or the link is down.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: While `rx_enabled` is low or `link_up` is low when the verdict is registered, the frame is rejected whatever its address and length.
- R2: A frame whose length is below the effective minimum is rejected. The effective minimum is `cfg_min_len`, or 5 when `cfg_min_len` is below 5.
- R3: With `cfg_promisc` high, every frame that passes R1 and R2 is accepted, and `res_group` stays low.
- R4: A destination of all ones (48 set bits) is broadcast. Without promiscuous mode it is rejected when `cfg_bcast_off` is high; otherwise it is accepted with `res_group` high.
- R5: A non-broadcast destination with bit 40 set (bit 0 of the first byte on the wire) is a group address. Without promiscuous mode it is rejected while `cfg_mcast_en` is low. Otherwise it is accepted, with `res_group` high, only when its hash table bit is set. `res_group` is never high on a rejected frame.
- R6: Any other destination is accepted, with `res_group` low, only when all 48 bits equal `station_addr`.
- R7: The hash index of an address is bits 7 down to 2 of a CRC-32 computed over its six bytes, most significant byte (`[47:40]`) first. Each byte is taken least significant bit first. The CRC uses reflected polynomial 0xEDB88320, starts from all ones, and is inverted at the end.
- R8: A `tbl_start` pulse clears all 64 table bits. The list length is then `tbl_byte_count / 6` addresses, rounded down. Streamed bytes beyond that count, including a trailing partial address, leave the table unchanged. Table bytes arrive on `tbl_byte` qualified by `tbl_byte_valid`, address by address, most significant byte first.
- R9: At most 64 addresses are taken from one load. Later addresses in the stream set no table bit.
- R10: The clock edge that samples `chk_valid` captures the request. `res_valid` then rises for exactly one cycle after the seventh following edge: six edges for the CRC bytes, and one edge for the registered verdict.
- R11: A `chk_valid` pulse that arrives while an earlier request is still being evaluated is ignored. No verdict is produced for it.
- R12: Synchronous reset drives `res_valid` low and empties the hash table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promisc | input | 1 | Accept every frame that passes the gate and length checks |
| cfg_bcast_off | input | 1 | Refuse broadcast frames |
| cfg_mcast_en | input | 1 | Allow group frames through the hash table |
| cfg_min_len | input | LEN_W | Configured minimum frame length (floored at 5) |
| station_addr | input | 48 | Own unicast address, first wire byte in [47:40] |
| rx_enabled | input | 1 | Receiver running; low rejects all |
| link_up | input | 1 | Link status; low rejects all |
| tbl_start | input | 1 | Begin a hash table load, clearing the table |
| tbl_byte_count | input | CNT_W | Byte count of the list, sampled with tbl_start |
| tbl_byte_valid | input | 1 | Qualifies tbl_byte |
| tbl_byte | input | 8 | Next list byte |
| chk_valid | input | 1 | Request strobe for a frame check |
| chk_dest | input | 48 | Destination address of the frame under test |
| chk_len | input | LEN_W | Length of the frame under test |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Frame accepted |
| res_group | output | 1 | Accepted frame is broadcast or group |

## Verification
The verdict is due exactly seven clock edges after the edge that captures `chk_valid`. The scoreboard therefore stamps each expected item with its due cycle when the request is driven. The monitor compares that stamp with the cycle in which `res_valid` is seen, sampling on the falling edge, so a result that arrives early or late fails even when its value is right.

A table bit becomes usable two edges after the sixth byte of its address is taken. The bench leaves several idle cycles after each load before it issues checks.

The bench spaces requests so that evaluations never overlap, except in the deliberate overlap case. In that case the second strobe has no queued item, so any verdict it produced would be reported as unexpected.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int          ADDR_BYTES = 6;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;

  typedef enum logic [1:0] {
    CLS_PROMISC = 2'd0,
    CLS_BCAST   = 2'd1,
    CLS_GROUP   = 2'd2,
    CLS_UNICAST = 2'd3
  } dest_class_e;

  // one byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxaf_crc_serial.sv
module rxaf_crc_serial
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic        last,
  input  logic [7:0]  din,
  output logic [31:0] crc_out,
  output logic        done
);

  logic [31:0] work_q;
  logic [31:0] next_c;

  always_comb next_c = crc_step(work_q, din);

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= CRC_SEED;
      crc_out <= '0;
      done    <= 1'b0;
    end else if (init) begin
      work_q <= CRC_SEED;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (en) begin
        if (last) begin
          crc_out <= ~next_c;
          work_q  <= CRC_SEED;
          done    <= 1'b1;
        end else begin
          work_q <= next_c;
        end
      end
    end
  end

endmodule

// File: rtl/rxaf_hash_loader.sv
module rxaf_hash_loader
  import rxaf_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MAX_ENTRIES = 64,
  parameter int HASH_BITS   = 6,
  localparam int TBL        = 1 << HASH_BITS,
  localparam int ENT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  output logic [TBL-1:0]   tbl_q,
  output logic [ENT_W-1:0] entries_left
);

  localparam logic [2:0] LAST_BYTE = 3'(ADDR_BYTES - 1);

  logic [2:0]       bidx;
  logic             take;
  logic             last_byte;
  logic [31:0]      crc_val;
  logic             crc_done;
  logic [CNT_W-1:0] quot;
  logic [HASH_BITS-1:0] set_idx;

  always_comb begin
    quot      = byte_count / CNT_W'(ADDR_BYTES);
    take      = byte_valid && !start && (entries_left != '0);
    last_byte = (bidx == LAST_BYTE);
    set_idx   = crc_val[HASH_BITS+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entries_left <= '0;
      bidx         <= '0;
    end else if (start) begin
      entries_left <= (quot > CNT_W'(MAX_ENTRIES)) ? ENT_W'(MAX_ENTRIES) : ENT_W'(quot);
      bidx         <= '0;
    end else if (take) begin
      if (last_byte) begin
        bidx         <= '0;
        entries_left <= entries_left - 1'b1;
      end else begin
        bidx <= bidx + 1'b1;
      end
    end
  end

  rxaf_crc_serial u_crc (
    .clk     (clk),
    .rst     (rst),
    .init    (start),
    .en      (take),
    .last    (last_byte),
    .din     (byte_in),
    .crc_out (crc_val),
    .done    (crc_done)
  );

  for (genvar g = 0; g < TBL; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst || start)                                  bit_q <= 1'b0;
      else if (crc_done && set_idx == HASH_BITS'(g))     bit_q <= 1'b1;
    end
    assign tbl_q[g] = bit_q;
  end

endmodule

// File: rtl/rxaf_check_seq.sv
module rxaf_check_seq
  import rxaf_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chk_valid,
  input  logic [47:0]          chk_dest,
  input  logic [LEN_W-1:0]     chk_len,
  output logic [47:0]          dest_q,
  output logic [LEN_W-1:0]     len_q,
  output logic [HASH_BITS-1:0] idx,
  output logic                 idx_valid
);

  localparam logic [2:0] LAST_BYTE = 3'(ADDR_BYTES - 1);

  logic        busy;
  logic        feeding;
  logic [2:0]  bidx;
  logic [47:0] sh;
  logic        capture;
  logic        last_byte;
  logic [31:0] crc_val;
  logic        crc_done;

  always_comb begin
    capture   = chk_valid && !busy;
    last_byte = (bidx == LAST_BYTE);
    idx       = crc_val[HASH_BITS+1:2];
    idx_valid = crc_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      feeding <= 1'b0;
      bidx    <= '0;
      sh      <= '0;
      dest_q  <= '0;
      len_q   <= '0;
    end else if (capture) begin
      busy    <= 1'b1;
      feeding <= 1'b1;
      bidx    <= '0;
      sh      <= chk_dest;
      dest_q  <= chk_dest;
      len_q   <= chk_len;
    end else begin
      if (feeding) begin
        sh <= sh << 8;
        if (last_byte) begin
          feeding <= 1'b0;
          bidx    <= '0;
        end else begin
          bidx <= bidx + 1'b1;
        end
      end
      if (crc_done) busy <= 1'b0;
    end
  end

  rxaf_crc_serial u_crc (
    .clk     (clk),
    .rst     (rst),
    .init    (capture),
    .en      (feeding),
    .last    (last_byte),
    .din     (sh[47:40]),
    .crc_out (crc_val),
    .done    (crc_done)
  );

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int HASH_BITS = 6,
  parameter int MIN_FLOOR = 5,
  localparam int TBL      = 1 << HASH_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eval,
  input  logic [47:0]          dest,
  input  logic [LEN_W-1:0]     len,
  input  logic [HASH_BITS-1:0] idx,
  input  logic [TBL-1:0]       tbl,
  input  logic                 cfg_promisc,
  input  logic                 cfg_bcast_off,
  input  logic                 cfg_mcast_en,
  input  logic [LEN_W-1:0]     cfg_min_len,
  input  logic [47:0]          station_addr,
  input  logic                 rx_enabled,
  input  logic                 link_up,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic                 res_group
);

  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_FLOOR);

  logic [LEN_W-1:0] eff_min;
  dest_class_e      cls;
  logic             gate_ok;
  logic             len_ok;
  logic             acc_d;
  logic             grp_d;

  always_comb begin
    eff_min = (cfg_min_len < FLOOR) ? FLOOR : cfg_min_len;
    gate_ok = rx_enabled && link_up;
    len_ok  = (len >= eff_min);

    if (cfg_promisc)   cls = CLS_PROMISC;
    else if (&dest)    cls = CLS_BCAST;
    else if (dest[40]) cls = CLS_GROUP;
    else               cls = CLS_UNICAST;

    acc_d = 1'b0;
    grp_d = 1'b0;
    unique case (cls)
      CLS_PROMISC: acc_d = 1'b1;
      CLS_BCAST: begin
        acc_d = !cfg_bcast_off;
        grp_d = 1'b1;
      end
      CLS_GROUP: begin
        acc_d = cfg_mcast_en && tbl[idx];
        grp_d = 1'b1;
      end
      CLS_UNICAST: acc_d = (dest == station_addr);
      default: acc_d = 1'b0;
    endcase
    acc_d = acc_d && gate_ok && len_ok;
    grp_d = grp_d && acc_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_group  <= 1'b0;
    end else begin
      res_valid <= eval;
      if (eval) begin
        res_accept <= acc_d;
        res_group  <= grp_d;
      end
    end
  end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 16,
  parameter int MAX_ENTRIES = 64,
  parameter int HASH_BITS   = 6,
  parameter int MIN_FLOOR   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_promisc,
  input  logic             cfg_bcast_off,
  input  logic             cfg_mcast_en,
  input  logic [LEN_W-1:0] cfg_min_len,
  input  logic [47:0]      station_addr,
  input  logic             rx_enabled,
  input  logic             link_up,
  input  logic             tbl_start,
  input  logic [CNT_W-1:0] tbl_byte_count,
  input  logic             tbl_byte_valid,
  input  logic [7:0]       tbl_byte,
  input  logic             chk_valid,
  input  logic [47:0]      chk_dest,
  input  logic [LEN_W-1:0] chk_len,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_group
);

  localparam int TBL   = 1 << HASH_BITS;
  localparam int ENT_W = $clog2(MAX_ENTRIES + 1);

  logic [TBL-1:0]       tbl_bits;
  logic [ENT_W-1:0]     load_left;
  logic [47:0]          dest_q;
  logic [LEN_W-1:0]     len_q;
  logic [HASH_BITS-1:0] chk_idx;
  logic                 chk_idx_valid;

  rxaf_hash_loader #(
    .CNT_W       (CNT_W),
    .MAX_ENTRIES (MAX_ENTRIES),
    .HASH_BITS   (HASH_BITS)
  ) u_load (
    .clk          (clk),
    .rst          (rst),
    .start        (tbl_start),
    .byte_count   (tbl_byte_count),
    .byte_valid   (tbl_byte_valid),
    .byte_in      (tbl_byte),
    .tbl_q        (tbl_bits),
    .entries_left (load_left)
  );

  rxaf_check_seq #(
    .LEN_W     (LEN_W),
    .HASH_BITS (HASH_BITS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .chk_valid (chk_valid),
    .chk_dest  (chk_dest),
    .chk_len   (chk_len),
    .dest_q    (dest_q),
    .len_q     (len_q),
    .idx       (chk_idx),
    .idx_valid (chk_idx_valid)
  );

  rxaf_decide #(
    .LEN_W     (LEN_W),
    .HASH_BITS (HASH_BITS),
    .MIN_FLOOR (MIN_FLOOR)
  ) u_dec (
    .clk           (clk),
    .rst           (rst),
    .eval          (chk_idx_valid),
    .dest          (dest_q),
    .len           (len_q),
    .idx           (chk_idx),
    .tbl           (tbl_bits),
    .cfg_promisc   (cfg_promisc),
    .cfg_bcast_off (cfg_bcast_off),
    .cfg_mcast_en  (cfg_mcast_en),
    .cfg_min_len   (cfg_min_len),
    .station_addr  (station_addr),
    .rx_enabled    (rx_enabled),
    .link_up       (link_up),
    .res_valid     (res_valid),
    .res_accept    (res_accept),
    .res_group     (res_group)
  );

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
  parameter int LEN_W       = 16,
  parameter int ENT_W       = 7,
  parameter int TBL         = 64,
  parameter int MAX_ENTRIES = 64,
  parameter int MIN_FLOOR   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tbl_start,
  input logic             cfg_promisc,
  input logic             rx_enabled,
  input logic             link_up,
  input logic             res_valid,
  input logic             res_accept,
  input logic             res_group,
  input logic [LEN_W-1:0] len_q,
  input logic [ENT_W-1:0] load_left,
  input logic [TBL-1:0]   tbl_bits
);

  a_r1_gate_rejects: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(rx_enabled && link_up)) |-> !res_accept);

  a_r2_length_floor: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_accept) |-> (len_q >= LEN_W'(MIN_FLOOR)));

  a_r3_promisc_no_flag: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(cfg_promisc)) |-> !res_group);

  a_r5_flag_needs_accept: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_group) |-> res_accept);

  a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
    $past(tbl_start) |-> (tbl_bits == '0));

  a_r9_entry_cap: assert property (@(posedge clk) disable iff (rst)
    load_left <= ENT_W'(MAX_ENTRIES));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r12_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !res_valid);

endmodule

bind eth_rx_addr_filter rxaf_checker #(
  .LEN_W       (LEN_W),
  .ENT_W       (ENT_W),
  .TBL         (TBL),
  .MAX_ENTRIES (MAX_ENTRIES),
  .MIN_FLOOR   (MIN_FLOOR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tbl_start   (tbl_start),
  .cfg_promisc (cfg_promisc),
  .rx_enabled  (rx_enabled),
  .link_up     (link_up),
  .res_valid   (res_valid),
  .res_accept  (res_accept),
  .res_group   (res_group),
  .len_q       (len_q),
  .load_left   (load_left),
  .tbl_bits    (tbl_bits)
);

// File: tb/eth_rx_addr_filter_test.sv
module eth_rx_addr_filter_test;

  localparam int LEN_W = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             cfg_promisc = 0, cfg_bcast_off = 0, cfg_mcast_en = 0;
  logic [LEN_W-1:0] cfg_min_len = '0;
  logic [47:0]      station_addr = 48'h02_11_22_33_44_55;
  logic             rx_enabled = 1, link_up = 1;
  logic             tbl_start = 0, tbl_byte_valid = 0;
  logic [CNT_W-1:0] tbl_byte_count = '0;
  logic [7:0]       tbl_byte = '0;
  logic             chk_valid = 0;
  logic [47:0]      chk_dest = '0;
  logic [LEN_W-1:0] chk_len = '0;
  logic             res_valid, res_accept, res_group;

  eth_rx_addr_filter uut (
    .clk(clk), .rst(rst), .cfg_promisc(cfg_promisc), .cfg_bcast_off(cfg_bcast_off),
    .cfg_mcast_en(cfg_mcast_en), .cfg_min_len(cfg_min_len), .station_addr(station_addr),
    .rx_enabled(rx_enabled), .link_up(link_up), .tbl_start(tbl_start),
    .tbl_byte_count(tbl_byte_count), .tbl_byte_valid(tbl_byte_valid), .tbl_byte(tbl_byte),
    .chk_valid(chk_valid), .chk_dest(chk_dest), .chk_len(chk_len),
    .res_valid(res_valid), .res_accept(res_accept), .res_group(res_group)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { bit acc; bit grp; int due; string req; } exp_t;
  exp_t sb[$];
  exp_t mon_e;

  logic [63:0] m_tbl = '0;
  logic [47:0] lst [0:79];

  function automatic logic [5:0] m_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ b[i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    c = ~c;
    return c[7:2];
  endfunction

  function automatic void model(input logic [47:0] d, input int len, output bit acc, output bit grp);
    int floor_len = (cfg_min_len < 5) ? 5 : int'(cfg_min_len);
    acc = 0; grp = 0;
    if (!rx_enabled || !link_up) return;
    if (len < floor_len) return;
    if (cfg_promisc) begin acc = 1; return; end
    if (&d) begin acc = !cfg_bcast_off; grp = acc; return; end
    if (d[40]) begin acc = cfg_mcast_en && m_tbl[m_idx(d)]; grp = acc; return; end
    acc = (d == station_addr);
  endfunction

  task automatic check_frame(input logic [47:0] d, input int len, input string req);
    bit a, g;
    model(d, len, a, g);
    @(negedge clk);
    chk_dest = d; chk_len = LEN_W'(len); chk_valid = 1;
    sb.push_back('{a, g, cyc + 8, req});
    @(negedge clk) chk_valid = 0;
    repeat (9) @(negedge clk);
  endtask

  task automatic load_table(input int nbytes);
    int n;
    @(negedge clk);
    tbl_start = 1; tbl_byte_count = CNT_W'(nbytes);
    @(negedge clk) tbl_start = 0;
    for (int k = 0; k < nbytes; k++) begin
      tbl_byte_valid = 1;
      tbl_byte = lst[k/6][47-8*(k%6) -: 8];
      @(negedge clk);
      if (k % 4 == 3) begin
        tbl_byte_valid = 0;
        @(negedge clk);
      end
    end
    tbl_byte_valid = 0;
    m_tbl = '0;
    n = nbytes / 6;
    if (n > 64) n = 64;
    for (int i = 0; i < n; i++) m_tbl[m_idx(lst[i])] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops the scoreboard as verdicts appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: unexpected verdict acc=%0b grp=%0b, expected none", res_accept, res_group);
      end else begin
        mon_e = sb.pop_front();
        n_chk++;
        if (res_accept !== mon_e.acc || res_group !== mon_e.grp) begin
          n_fail++;
          $display("FAIL %s: acc/grp = %0b/%0b, expected %0b/%0b",
                   mon_e.req, res_accept, res_group, mon_e.acc, mon_e.grp);
        end
        n_chk++;
        if (cyc != mon_e.due) begin
          n_fail++;
          $display("FAIL R10: verdict for %s in cycle %0d, expected %0d", mon_e.req, cyc, mon_e.due);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10: watchdog expired, got hang, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12: res_valid = %0b after reset, expected 0", res_valid);
    end

    // R12: table empty after reset
    cfg_mcast_en = 1;
    check_frame(48'h01_00_5E_00_00_01, 64, "R12");

    // R6: unicast
    check_frame(station_addr, 64, "R6");
    check_frame(station_addr ^ 48'h1, 64, "R6");
    check_frame(station_addr ^ 48'h0000_0100_0000, 64, "R6");

    // R4: broadcast
    check_frame('1, 64, "R4");
    cfg_bcast_off = 1;
    check_frame('1, 64, "R4");
    cfg_bcast_off = 0;

    // R2: length floor and configured minimum
    check_frame(station_addr, 4, "R2");
    check_frame(station_addr, 5, "R2");
    cfg_min_len = 64;
    check_frame(station_addr, 63, "R2");
    check_frame(station_addr, 64, "R2");
    cfg_min_len = 2;
    check_frame(station_addr, 4, "R2");
    check_frame(station_addr, 5, "R2");
    cfg_min_len = 0;

    // R7 / R8: 13 bytes -> two addresses, trailing byte ignored
    lst[0] = 48'h01_00_5E_00_00_01;
    lst[1] = 48'h33_33_00_00_00_01;
    lst[2] = 48'hAB_CD_EF_01_23_45;
    load_table(13);
    check_frame(lst[0], 64, "R7");
    check_frame(lst[1], 64, "R7");
    check_frame(48'h01_00_5E_7F_00_02, 64, "R7");
    check_frame(48'h01_00_5E_00_00_07, 64, "R8");

    // R5: group frames refused when disabled
    cfg_mcast_en = 0;
    check_frame(lst[0], 64, "R5");
    cfg_mcast_en = 1;
    check_frame(lst[1], 64, "R5");

    // R8: reload clears old contents
    lst[0] = 48'h01_00_5E_00_00_FB;
    load_table(6);
    check_frame(48'h01_00_5E_00_00_01, 64, "R8");
    check_frame(48'h33_33_00_00_00_01, 64, "R8");
    check_frame(lst[0], 64, "R8");

    // R9: cap at 64 addresses
    for (int i = 0; i < 64; i++) lst[i] = 48'h01_00_5E_00_00_10;
    for (int i = 64; i < 70; i++) lst[i] = 48'h01_00_5E_01_00_00 | 48'(i * 37);
    load_table(420);
    check_frame(lst[0], 64, "R9");
    for (int i = 64; i < 70; i++) check_frame(lst[i], 64, "R9");

    // R3: promiscuous
    cfg_promisc = 1;
    check_frame(48'h04_99_88_77_66_55, 64, "R3");
    cfg_bcast_off = 1;
    check_frame('1, 64, "R3");
    cfg_bcast_off = 0;
    check_frame(48'h01_00_5E_55_55_55, 64, "R3");
    check_frame(48'h04_99_88_77_66_55, 3, "R3");
    cfg_promisc = 0;

    // R1: gating
    rx_enabled = 0;
    check_frame(station_addr, 64, "R1");
    rx_enabled = 1; link_up = 0;
    check_frame('1, 64, "R1");
    link_up = 1;
    check_frame(station_addr, 64, "R1");

    // R11: second strobe while busy is ignored
    begin
      bit a, g;
      model(station_addr, 64, a, g);
      @(negedge clk);
      chk_dest = station_addr; chk_len = 64; chk_valid = 1;
      sb.push_back('{a, g, cyc + 8, "R11"});
      @(negedge clk) chk_valid = 0;
      @(negedge clk);
      chk_dest = '1; chk_len = 64; chk_valid = 1;
      @(negedge clk) chk_valid = 0;
      repeat (15) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d verdicts missing, expected 0", sb.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule